// File: doc/BRIEF.md
# Cascadable Bit-Slice Arithmetic/Logic Unit

This block is a purely combinational arithmetic/logic unit assembled from a chain of identical one-bit slices. It has no clock and no reset. Every slice takes one bit of each operand and a carry from the slice below it. It produces one result bit and passes a carry to the slice above. The carry-in of the lowest slice is a port, and so is the carry-out of the highest slice. Two units can therefore be chained to form a wider datapath.

A mode input chooses between an arithmetic group and a logic group of four operations each. A two-bit select picks the operation within the group. In the arithmetic group the carry-in is part of the function: it turns transfer into increment, one's complement into two's complement, and complement-plus-B into B minus A. In the logic group the result is computed bit by bit, the incoming carry has no effect, and the carry-out is held at zero. The width is a parameter and defaults to 8.

Top module: `slice_alu`

## Requirements
- R1: With mode_i=0 and sel_i=00, {cout_o, f_o} equals a_i + cin_i (transfer when cin_i=0, increment when cin_i=1).
- R2: With mode_i=0 and sel_i=01, {cout_o, f_o} equals (~a_i) + cin_i (one's complement when cin_i=0, two's complement when cin_i=1).
- R3: With mode_i=0 and sel_i=10, {cout_o, f_o} equals a_i + b_i + cin_i.
- R4: With mode_i=0 and sel_i=11, {cout_o, f_o} equals (~a_i) + b_i + cin_i. With cin_i=1, f_o is b_i - a_i modulo 2^W, and cout_o is 1 exactly when b_i >= a_i.
- R5: With mode_i=1 and sel_i=00, f_o equals a_i.
- R6: With mode_i=1 and sel_i=01, f_o equals ~a_i.
- R7: With mode_i=1 and sel_i=10, f_o equals a_i | b_i.
- R8: With mode_i=1 and sel_i=11, f_o equals (~a_i) | b_i.
- R9: With mode_i=1, cout_o is 0 and cin_i has no effect on f_o.
- R10: The carry ripples through every slice. Example: a_i all ones, b_i=0, sel_i=10, mode_i=0, cin_i=1 gives f_o=0 and cout_o=1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_i | input | W | Operand A |
| b_i | input | W | Operand B |
| cin_i | input | 1 | Carry into the lowest slice |
| mode_i | input | 1 | 0 = arithmetic group, 1 = logic group |
| sel_i | input | 2 | Operation within the group |
| f_o | output | W | Result |
| cout_o | output | 1 | Carry out of the highest slice; 0 in logic mode |

## Verification
Two effects can act on the same result. The first is a carry-in that ripples through every slice. The second is the mode choice that must block that carry. The bench applies cin_i=1 with all-ones and mixed operands in both groups. It then requires a carry all the way to cout_o in the arithmetic group, and an unchanged result with a zero carry-out in the logic group. A behavioural reference computes every expected value with integer arithmetic, and the outputs are compared on every clock of the bench.

// File: rtl/slice_alu_pkg.sv
package slice_alu_pkg;

  localparam logic [1:0] SEL_PASS   = 2'b00;
  localparam logic [1:0] SEL_INV    = 2'b01;
  localparam logic [1:0] SEL_WITH_B = 2'b10;
  localparam logic [1:0] SEL_INV_B  = 2'b11;

  typedef struct packed {
    logic inv_a;   // first adder input is ~a
    logic use_b;   // second adder input is b, else 0
    logic logic_g; // logic group: no carry
  } slice_ctrl_t;

endpackage

// File: rtl/slice_alu_decode.sv
module slice_alu_decode
  import slice_alu_pkg::*;
(
  input  logic        mode_i,
  input  logic [1:0]  sel_i,
  output slice_ctrl_t ctrl_o
);

  always_comb begin
    ctrl_o.inv_a   = sel_i[0];
    ctrl_o.use_b   = sel_i[1];
    ctrl_o.logic_g = mode_i;
  end

endmodule

// File: rtl/slice_alu_bit.sv
module slice_alu_bit
  import slice_alu_pkg::*;
(
  input  slice_ctrl_t ctrl_i,
  input  logic        a_i,
  input  logic        b_i,
  input  logic        c_i,
  output logic        f_o,
  output logic        c_o
);

  logic a_op, b_op, half;

  always_comb begin
    a_op = ctrl_i.inv_a ? ~a_i : a_i;
    b_op = ctrl_i.use_b ? b_i : 1'b0;
    half = a_op ^ b_op;
    if (ctrl_i.logic_g) begin
      f_o = ctrl_i.use_b ? (a_op | b_i) : a_op;
      c_o = 1'b0;
    end else begin
      f_o = half ^ c_i;
      c_o = (a_op & b_op) | (c_i & half);
    end
  end

endmodule

// File: rtl/slice_alu.sv
module slice_alu
  import slice_alu_pkg::*;
#(
  parameter int W = 8
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic         cin_i,
  input  logic         mode_i,
  input  logic [1:0]   sel_i,
  output logic [W-1:0] f_o,
  output logic         cout_o
);

  localparam int CW = W + 1;

  slice_ctrl_t     ctrl;
  logic [CW-1:0]   carry;

  slice_alu_decode u_dec (
    .mode_i (mode_i),
    .sel_i  (sel_i),
    .ctrl_o (ctrl)
  );

  assign carry[0] = cin_i;

  for (genvar i = 0; i < W; i++) begin : g_slice
    slice_alu_bit u_bit (
      .ctrl_i (ctrl),
      .a_i    (a_i[i]),
      .b_i    (b_i[i]),
      .c_i    (carry[i]),
      .f_o    (f_o[i]),
      .c_o    (carry[i+1])
    );
  end

  assign cout_o = carry[W];

  // operand-level checks on the slice chain
  logic [CW-1:0] ext_a, ext_b, ext_na, ext_c;
  always_comb begin
    ext_a  = {1'b0, a_i};
    ext_b  = {1'b0, b_i};
    ext_na = {1'b0, ~a_i};
    ext_c  = {{W{1'b0}}, cin_i};
    if (!mode_i && sel_i == SEL_PASS && !cin_i)
      a_r1_transfer: assert (f_o == a_i && !cout_o);
    if (!mode_i && sel_i == SEL_WITH_B)
      a_r3_add: assert ({cout_o, f_o} == ext_a + ext_b + ext_c);
    if (!mode_i && sel_i == SEL_INV_B && cin_i)
      a_r4_sub: assert (f_o == W'(b_i - a_i) && cout_o == (b_i >= a_i));
    if (!mode_i && sel_i == SEL_INV)
      a_r2_complement: assert ({cout_o, f_o} == ext_na + ext_c);
    if (mode_i)
      a_r9_no_logic_carry: assert (!cout_o);
    if (mode_i && sel_i == SEL_INV_B)
      a_r8_or_not: assert (f_o == (~a_i | b_i));
  end

endmodule

// File: tb/slice_alu_test.sv
module slice_alu_test;

  localparam int W = 8;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [W-1:0] a, b, f;
  logic         cin, mode, cout;
  logic [1:0]   sel;
  int           checks = 0;
  int           failures = 0;
  int           cycles = 0;
  bit           done = 1'b0;

  always #2.5 clk = ~clk;

  slice_alu #(.W(W)) uut (
    .a_i    (a),
    .b_i    (b),
    .cin_i  (cin),
    .mode_i (mode),
    .sel_i  (sel),
    .f_o    (f),
    .cout_o (cout)
  );

  function automatic logic [W:0] model(input logic m, input logic [1:0] s,
                                       input logic [W-1:0] x, input logic [W-1:0] y,
                                       input logic c);
    int ai, bi, sum;
    ai = int'(x);
    bi = int'(y);
    if (!m) begin
      if (s[0]) ai = (~ai) & ((1 << W) - 1);
      if (!s[1]) bi = 0;
      sum = ai + bi + int'(c);
      return (W+1)'(sum);
    end
    case (s)
      2'b00:   return {1'b0, x};
      2'b01:   return {1'b0, ~x};
      2'b10:   return {1'b0, x | y};
      default: return {1'b0, ~x | y};
    endcase
  endfunction

  function automatic string tag_of(input logic m, input logic [1:0] s);
    case ({m, s})
      3'b000:  return "R1";
      3'b001:  return "R2";
      3'b010:  return "R3";
      3'b011:  return "R4";
      3'b100:  return "R5";
      3'b101:  return "R6";
      3'b110:  return "R7";
      default: return "R8";
    endcase
  endfunction

  task automatic compare(input string req, input logic [W:0] got, input logic [W:0] exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s: mode=%0b sel=%02b a=%02h b=%02h cin=%0b got {cout,f}=%03h expected %03h",
               req, mode, sel, a, b, cin, got, exp);
    end
  endtask

  task automatic apply(input logic m, input logic [1:0] s, input logic [W-1:0] x,
                       input logic [W-1:0] y, input logic c);
    @(posedge clk);
    mode = m; sel = s; a = x; b = y; cin = c;
    @(negedge clk);
    compare(tag_of(m, s), {cout, f}, model(m, s, x, y, c));
  endtask

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000 && !done) begin
      failures++;
      $display("FAIL watchdog: cycles=%0d expected completion", cycles);
      summary();
    end
  end

  initial begin
    logic [W-1:0] corners [4];
    logic [W:0]   with_c0;
    corners[0] = 8'h00; corners[1] = 8'hFF; corners[2] = 8'h80; corners[3] = 8'h7F;
    mode = 1'b0; sel = 2'b00; a = '0; b = '0; cin = 1'b0;
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: idle zero inputs after bench reset
    compare("R1", {cout, f}, '0);

    // all operations, both carries, corner operands
    for (int op = 0; op < 8; op++)
      for (int c = 0; c < 2; c++)
        for (int i = 0; i < 4; i++)
          for (int j = 0; j < 4; j++)
            apply(op[2], op[1:0], corners[i], corners[j], c[0]);

    // random operands
    for (int k = 0; k < 400; k++)
      apply($urandom_range(1, 0) != 0, 2'($urandom_range(3, 0)),
            W'($urandom), W'($urandom), $urandom_range(1, 0) != 0);

    // R10: full-length ripple
    apply(1'b0, 2'b10, 8'hFF, 8'h00, 1'b1);
    compare("R10", {cout, f}, 9'h100);
    apply(1'b0, 2'b00, 8'hFF, 8'h5A, 1'b1);
    compare("R10", {cout, f}, 9'h100);
    // R2: two's complement of zero wraps with carry
    apply(1'b0, 2'b01, 8'h00, 8'h00, 1'b1);
    compare("R2", {cout, f}, 9'h100);
    // R4: B - A with borrow and without
    apply(1'b0, 2'b11, 8'h05, 8'h03, 1'b1);
    compare("R4", {cout, f}, 9'h0FE);
    apply(1'b0, 2'b11, 8'h03, 8'h05, 1'b1);
    compare("R4", {cout, f}, 9'h102);

    // R9: carry-in ignored in the logic group
    for (int s = 0; s < 4; s++) begin
      apply(1'b1, 2'(s), 8'hFF, 8'h0F, 1'b0);
      with_c0 = {cout, f};
      apply(1'b1, 2'(s), 8'hFF, 8'h0F, 1'b1);
      compare("R9", {cout, f}, with_c0);
      compare("R9", {8'h00, cout}, 9'h000);
    end

    done = 1'b1;
    summary();
  end

endmodule